// File: doc/BRIEF.md
# Total-Store-Order Store Buffer

This block sits between one processor core's memory request port and a shared, single-ported memory. It gives the core total-store-order behaviour. Stores are queued in a small FIFO and written to memory later, oldest first. Loads do not wait for queued stores; they read memory at once. Other agents on the same memory can therefore see a store late, while the issuing core always sees its own stores through forwarding. A fence, or a locked atomic swap, cannot proceed until the FIFO is empty. This restores store-before-load ordering at the points where software asks for it.

The core side is a valid/ready request channel carrying an opcode, an address and write data. Back-pressure works as follows: a request is taken in the cycle where both `req_valid` and `req_ready` are high. The core must hold the request stable while `req_ready` is low, and must not issue younger requests past it. Load and atomic results come back on `rsp_valid`/`rsp_data` one cycle after acceptance, with no back-pressure on that path. A fence returns a one-cycle `fence_done` pulse instead. The memory side is a request/grant port with combinational read data equal to the current contents of `mem_addr`.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the FIFO is empty, `rsp_valid`, `fence_done` and `mem_req` are low, and `req_ready` is high for a store (opcode 0).
- R2: An accepted store (opcode 0) is placed in the FIFO and does not change memory in its acceptance cycle; `req_ready` is high for a store while the FIFO is not full.
- R3: When the FIFO holds DEPTH entries, `req_ready` for a store is low until an entry has been written to memory.
- R4: Queued stores are written to memory strictly oldest first, one entry per cycle in which the memory write is granted and no load or atomic uses the port.
- R5: A load (opcode 1) to an address with no queued store reads memory through the port without waiting for queued stores to other addresses; it takes the port ahead of the drain, and its data appears on `rsp_data` with `rsp_valid` high one cycle after acceptance.
- R6: A load to an address with queued stores returns the data of the youngest matching queued store and makes no memory read.
- R7: A fence (opcode 2) is not accepted until the FIFO is empty, so every younger request waits behind it; `fence_done` pulses high for exactly one cycle, the cycle after acceptance.
- R8: An atomic swap (opcode 3) is accepted only once the FIFO is empty and the port is granted; it writes `req_wdata` to memory and returns the previous memory word on `rsp_data` one cycle later.
- R9: With two instances on one memory, the store-then-load pattern without fences can end with both loads reading zero; with a fence between each store and load that outcome cannot occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 2 | 0 store, 1 load, 2 fence, 3 atomic swap |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Store / swap data |
| rsp_valid | output | 1 | Load or swap result valid |
| rsp_data | output | DW | Load or swap result |
| fence_done | output | 1 | One-cycle pulse when a fence completes |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory access granted this cycle |
| mem_rdata | input | DW | Current memory word at mem_addr |

## Verification
The bench holds back memory writes so that stores pile up. This exposes a drain that reorders entries or overwrites a slot, and a full FIFO that still accepts a store and loses data. A load that waits for the drain shows up as stale-free but late data when writes are stalled. A forwarding search that picks the oldest match returns the first of two stores to one address. A fence or swap accepted with entries queued leaves an old word in memory, or returns an old swap value. The two-core litmus run shows whether loads really bypass, and whether fences really restore ordering.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  typedef enum logic [1:0] {
    OP_STORE  = 2'd0,
    OP_LOAD   = 2'd1,
    OP_FENCE  = 2'd2,
    OP_ATOMIC = 2'd3
  } tsb_op_e;
endpackage

// File: rtl/tsb_fifo.sv
module tsb_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [AW-1:0]       push_addr,
  input  logic [DW-1:0]       push_data,
  input  logic                pop,
  output logic [AW-1:0]       head_addr,
  output logic [DW-1:0]       head_data,
  output logic                empty,
  output logic                full,
  output logic [PW-1:0]       rd_ptr,
  output logic [DEPTH-1:0]    slot_valid,
  output logic [DEPTH*AW-1:0] slot_addr,
  output logic [DEPTH*DW-1:0] slot_data
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PW-1:0] wr_q, rd_q;
  logic [PW:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      vld_q <= '0;
    end else begin
      if (push) begin
        addr_q[wr_q] <= push_addr;
        data_q[wr_q] <= push_data;
        vld_q[wr_q]  <= 1'b1;
        wr_q         <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
      if (pop) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
      cnt_q <= cnt_q + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == (PW+1)'(DEPTH));
  assign head_addr  = addr_q[rd_q];
  assign head_data  = data_q[rd_q];
  assign rd_ptr     = rd_q;
  assign slot_valid = vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign slot_addr[g*AW +: AW] = addr_q[g];
    assign slot_data[g*DW +: DW] = data_q[g];
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/tsb_fwd.sv
module tsb_fwd #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [AW-1:0]       look_addr,
  input  logic [PW-1:0]       rd_ptr,
  input  logic [DEPTH-1:0]    slot_valid,
  input  logic [DEPTH*AW-1:0] slot_addr,
  input  logic [DEPTH*DW-1:0] slot_data,
  output logic                hit,
  output logic [DW-1:0]       hit_data
);
  logic [PW-1:0] idx;

  // Walk from oldest to youngest; a later match replaces an earlier one.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    idx      = rd_ptr;
    for (int i = 0; i < DEPTH; i++) begin
      idx = PW'((int'(rd_ptr) + i) % DEPTH);
      if (slot_valid[idx] && slot_addr[idx*AW +: AW] == look_addr) begin
        hit      = 1'b1;
        hit_data = slot_data[idx*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
  import tsb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          fence_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata
);
  tsb_op_e op;
  logic is_store, is_load, is_fence, is_atomic;
  logic empty, full, push, pop, fire;
  logic fwd_hit, load_mem, atomic_go, core_port;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, fwd_data;
  logic [PW-1:0] rd_ptr;
  logic [DEPTH-1:0]    slot_valid;
  logic [DEPTH*AW-1:0] slot_addr;
  logic [DEPTH*DW-1:0] slot_data;

  assign op        = tsb_op_e'(req_op);
  assign is_store  = (op == OP_STORE);
  assign is_load   = (op == OP_LOAD);
  assign is_fence  = (op == OP_FENCE);
  assign is_atomic = (op == OP_ATOMIC);

  tsb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk, .rst_n, .push, .push_addr(req_addr), .push_data(req_wdata),
    .pop, .head_addr, .head_data, .empty, .full, .rd_ptr,
    .slot_valid, .slot_addr, .slot_data
  );

  tsb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .look_addr(req_addr), .rd_ptr, .slot_valid, .slot_addr, .slot_data,
    .hit(fwd_hit), .hit_data(fwd_data)
  );

  // Core-side accesses own the port ahead of the drain.
  assign load_mem  = req_valid && is_load && !fwd_hit;
  assign atomic_go = req_valid && is_atomic && empty;
  assign core_port = load_mem || atomic_go;

  assign mem_req   = core_port || !empty;
  assign mem_we    = core_port ? is_atomic : 1'b1;
  assign mem_addr  = core_port ? req_addr  : head_addr;
  assign mem_wdata = core_port ? req_wdata : head_data;
  assign pop       = !core_port && !empty && mem_gnt;

  always_comb begin
    unique case (op)
      OP_STORE:  req_ready = !full;
      OP_LOAD:   req_ready = fwd_hit || mem_gnt;
      OP_FENCE:  req_ready = empty;
      OP_ATOMIC: req_ready = empty && mem_gnt;
      default:   req_ready = 1'b0;
    endcase
  end

  assign fire = req_valid && req_ready;
  assign push = fire && is_store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      fence_done <= 1'b0;
    end else begin
      rsp_valid  <= fire && (is_load || is_atomic);
      fence_done <= fire && is_fence;
      if (fire && (is_load || is_atomic))
        rsp_data <= (is_load && fwd_hit) ? fwd_data : mem_rdata;
    end
  end

  assert_load_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_load) |=> rsp_valid);
  assert_fwd_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_load && fwd_hit) |-> (!mem_req || mem_we));
  assert_fence_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> $past(empty));
  assert_atomic_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_atomic) |-> empty);
endmodule

// File: tb/tso_store_buffer_tb.sv
module tso_store_buffer_tb;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          vld_a = 0, vld_b = 0, rdy_a, rdy_b;
  logic [1:0]    op_a = 0, op_b = 0;
  logic [AW-1:0] ad_a = 0, ad_b = 0;
  logic [DW-1:0] wd_a = 0, wd_b = 0;
  logic          rv_a, rv_b, fd_a, fd_b;
  logic [DW-1:0] rd_a, rd_b;
  logic          mreq_a, mreq_b, mwe_a, mwe_b, gnt_a, gnt_b;
  logic [AW-1:0] madr_a, madr_b;
  logic [DW-1:0] mwd_a, mwd_b, mrd_a, mrd_b;

  int checks = 0, errors = 0;
  logic blk = 0, clr = 0, poke = 0;
  logic [AW-1:0] poke_a = 0;
  logic [DW-1:0] poke_d = 0;
  logic [DW-1:0] mem [1<<AW];
  logic [AW-1:0] log_adr [16];
  logic [DW-1:0] log_dat [16];
  int log_n = 0;

  assign gnt_a = mreq_a && !(blk && mwe_a);
  assign gnt_b = mreq_b && !(blk && mwe_b) && !gnt_a;
  assign mrd_a = mem[madr_a];
  assign mrd_b = mem[madr_b];

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] <= '0;
      log_n <= 0;
    end else begin
      if (poke) mem[poke_a] <= poke_d;
      if (gnt_a && mwe_a) begin
        mem[madr_a] <= mwd_a;
        if (log_n < 16) begin
          log_adr[log_n] <= madr_a;
          log_dat[log_n] <= mwd_a;
          log_n <= log_n + 1;
        end
      end
      if (gnt_b && mwe_b) mem[madr_b] <= mwd_b;
    end
  end

  tso_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk, .rst_n, .req_valid(vld_a), .req_ready(rdy_a), .req_op(op_a),
    .req_addr(ad_a), .req_wdata(wd_a), .rsp_valid(rv_a), .rsp_data(rd_a),
    .fence_done(fd_a), .mem_req(mreq_a), .mem_we(mwe_a), .mem_addr(madr_a),
    .mem_wdata(mwd_a), .mem_gnt(gnt_a), .mem_rdata(mrd_a));

  tso_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut_b (
    .clk, .rst_n, .req_valid(vld_b), .req_ready(rdy_b), .req_op(op_b),
    .req_addr(ad_b), .req_wdata(wd_b), .rsp_valid(rv_b), .rsp_data(rd_b),
    .fence_done(fd_b), .mem_req(mreq_b), .mem_we(mwe_b), .mem_addr(madr_b),
    .mem_wdata(mwd_b), .mem_gnt(gnt_b), .mem_rdata(mrd_b));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reset_mem();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic preset(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk) begin poke = 1; poke_a = a; poke_d = d; end
    @(negedge clk) poke = 0;
  endtask

  // Issue one request on core c; returns response data / valid and fence pulse.
  task automatic issue(input bit c, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] rd,
                       output logic rv, output logic done);
    @(negedge clk);
    if (c) begin vld_b = 1; op_b = op; ad_b = a; wd_b = d; end
    else   begin vld_a = 1; op_a = op; ad_a = a; wd_a = d; end
    while (1) begin
      #1;
      if (c ? rdy_b : rdy_a) break;
      @(negedge clk);
    end
    @(posedge clk); #1;
    rd   = c ? rd_b : rd_a;
    rv   = c ? rv_b : rv_a;
    done = c ? fd_b : fd_a;
    if (c) vld_b = 0; else vld_a = 0;
  endtask

  task automatic settle();
    repeat (DEPTH + 6) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); op_a = 2'd0; #1;
    chk("R1 store ready", 32'(rdy_a), 1);
    chk("R1 rsp_valid", 32'(rv_a), 0);
    chk("R1 fence_done", 32'(fd_a), 0);
    chk("R1 mem_req", 32'(mreq_a), 0);
  endtask

  task automatic t_store_order();
    logic [DW-1:0] r; logic v, f;
    reset_mem();
    blk = 1;
    issue(0, 2'd0, 8'h02, 32'd10, r, v, f);
    chk("R2 memory untouched", mem[2], 0);
    issue(0, 2'd0, 8'h03, 32'd11, r, v, f);
    issue(0, 2'd0, 8'h02, 32'd12, r, v, f);
    blk = 0;
    settle();
    chk("R4 write count", 32'(log_n), 3);
    chk("R4 first addr", 32'(log_adr[0]), 2);
    chk("R4 first data", log_dat[0], 10);
    chk("R4 second data", log_dat[1], 11);
    chk("R4 third data", log_dat[2], 12);
    chk("R4 final word", mem[2], 12);
  endtask

  task automatic t_full();
    logic [DW-1:0] r; logic v, f;
    reset_mem();
    blk = 1;
    for (int i = 0; i < DEPTH; i++) issue(0, 2'd0, AW'(8'h40 + i), DW'(i + 1), r, v, f);
    @(negedge clk); op_a = 2'd0; ad_a = 8'h50; wd_a = 32'd99; #1;
    chk("R3 ready low when full", 32'(rdy_a), 0);
    repeat (2) @(posedge clk); #1;
    chk("R3 still low while stalled", 32'(rdy_a), 0);
    blk = 0;
    issue(0, 2'd0, 8'h50, 32'd99, r, v, f);
    settle();
    chk("R3 oldest written", mem[8'h40], 1);
    chk("R3 late store kept", mem[8'h50], 99);
  endtask

  task automatic t_bypass_fwd();
    logic [DW-1:0] r; logic v, f;
    reset_mem();
    preset(8'h06, 32'd33);
    blk = 1;
    issue(0, 2'd0, 8'h05, 32'd7, r, v, f);
    issue(0, 2'd1, 8'h06, 32'd0, r, v, f);
    chk("R5 bypass load data", r, 33);
    chk("R5 rsp_valid", 32'(v), 1);
    chk("R5 store still queued", mem[5], 0);
    issue(0, 2'd1, 8'h05, 32'd0, r, v, f);
    chk("R6 forward single", r, 7);
    issue(0, 2'd0, 8'h05, 32'd8, r, v, f);
    issue(0, 2'd1, 8'h05, 32'd0, r, v, f);
    chk("R6 forward youngest", r, 8);
    blk = 0;
    settle();
    chk("R4 drained final", mem[5], 8);
  endtask

  task automatic t_fence();
    logic [DW-1:0] r; logic v, f;
    reset_mem();
    blk = 1;
    issue(0, 2'd0, 8'h09, 32'd1, r, v, f);
    @(negedge clk); op_a = 2'd2; #1;
    chk("R7 fence held while queued", 32'(rdy_a), 0);
    blk = 0;
    issue(0, 2'd2, 8'h00, 32'd0, r, v, f);
    chk("R7 fence_done pulse", 32'(f), 1);
    chk("R7 drained before done", mem[9], 1);
    @(posedge clk); #1;
    chk("R7 pulse one cycle", 32'(fd_a), 0);
  endtask

  task automatic t_atomic();
    logic [DW-1:0] r; logic v, f;
    reset_mem();
    preset(8'h0C, 32'd4);
    blk = 1;
    issue(0, 2'd0, 8'h0C, 32'd6, r, v, f);
    fork
      begin repeat (4) @(posedge clk); blk = 0; end
      issue(0, 2'd3, 8'h0C, 32'd20, r, v, f);
    join
    chk("R8 swap returns drained value", r, 6);
    chk("R8 swap rsp_valid", 32'(v), 1);
    @(posedge clk); #1;
    chk("R8 swap wrote memory", mem[8'h0C], 20);
  endtask

  task automatic t_litmus(input bit fenced);
    logic [DW-1:0] ra, rb; logic v, f;
    reset_mem();
    blk = 1;
    fork
      begin
        issue(0, 2'd0, 8'h20, 32'd1, ra, v, f);
        if (fenced) issue(0, 2'd2, 8'h00, 32'd0, ra, v, f);
        issue(0, 2'd1, 8'h21, 32'd0, ra, v, f);
      end
      begin
        issue(1, 2'd0, 8'h21, 32'd1, rb, v, f);
        if (fenced) issue(1, 2'd2, 8'h00, 32'd0, rb, v, f);
        issue(1, 2'd1, 8'h20, 32'd0, rb, v, f);
      end
      begin repeat (6) @(posedge clk); blk = 0; end
    join
    settle();
    if (fenced) chk("R9 fenced never both zero", 32'(ra == 0 && rb == 0), 0);
    else        chk("R9 unfenced both zero", 32'(ra == 0 && rb == 0), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_store_order();
    t_full();
    t_bypass_fwd();
    t_fence();
    t_atomic();
    t_litmus(0);
    t_litmus(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule